// File: doc/BRIEF.md
# Test Pin Source Selector with Divider Bypass

This block drives one test pin from one of eight sources picked by a 3-bit select code. The sources are the serial shift chain's output bit, two constant levels, the reference clock divided by 16, the M feedback counter output, the main output clock, and the main output clock divided by 4. One code sets bypass mode. In bypass mode the slow serial clock replaces the PLL as the source for the divider chain. The N post-divider then drives the main output, and the M counter drives the test pin.

All logic runs on one fast system clock. The serial, main and reference clock inputs are slow, synchronous levels that are sampled each cycle. Each divider advances on a detected rising edge of its source. Whenever the select code changes, every divider returns to zero, so a new mode always starts from a known phase. Outside bypass the main output passes the main clock input through unchanged.

Top module: `test_sel_bypass`

## Requirements
- R1: While reset is asserted with select code 110, both `test_o` and `fout_o` are 0.
- R2: With code 000, `test_o` shows the `sdo_i` value captured at the most recent rising edge of `sclk_i`. Changes on `sdo_i` between edges do not reach the pin.
- R3: Code 001 drives `test_o` to 1 and code 101 drives it to 0, whatever the clock inputs do.
- R4: With code 010, `test_o` is the reference clock divided by 16 with a 50% duty cycle. After k rising edges of `ref_clk_i`, it equals bit 3 of k.
- R5: With code 011, `test_o` is the M counter clocked by `pll_clk_i` rising edges. After k edges it is high exactly when k is a multiple of M (for M ≥ 2), and it holds that level until the next edge.
- R6: With code 100, `test_o` follows `pll_clk_i` directly. With code 111, `test_o` is `pll_clk_i` divided by 4, equal to bit 1 of the edge count k.
- R7: With code 110 (bypass), `fout_o` toggles after every N rising edges of `sclk_i`, where `n_code_i` 00/01/10/11 gives N = 1/2/4/8. The output period is therefore 2·N serial clocks.
- R8: In bypass, `test_o` is the M counter clocked by `sclk_i` rising edges, using the same rule as R5.
- R9: An M value of 0 or 1 makes the M counter output high after every rising edge of its source.
- R10: A change of select code clears all dividers, so counting after the change starts from zero.
- R11: Outside bypass, `fout_o` equals `pll_clk_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tsel_i | input | 3 | Test source select code |
| m_val_i | input | 9 | M counter modulus |
| n_code_i | input | 2 | Post-divide code (N = 2^code) |
| sclk_i | input | 1 | Serial clock level |
| sdo_i | input | 1 | Serial shift chain output bit |
| pll_clk_i | input | 1 | Main output clock level (PLL path) |
| ref_clk_i | input | 1 | Reference clock level |
| test_o | output | 1 | Test pin |
| fout_o | output | 1 | Main output (N divider in bypass) |

## Verification
The hardest case to reach from the ports is a divider left partly counted when the select code changes. Without the restart, the next mode would begin at an unknown phase. The bench parks the N divider midway through a half period in bypass, leaves bypass and comes back. It then checks that one serial edge alone does not toggle `fout_o`. The M counter is checked the same way: a partial count is followed by a mode change, and the bench checks that the next pulse comes a full M edges later.

// File: rtl/test_sel_pkg.sv
package test_sel_pkg;
  typedef enum logic [2:0] {
    SEL_SHIFT = 3'b000,
    SEL_ONE   = 3'b001,
    SEL_REF16 = 3'b010,
    SEL_MCNT  = 3'b011,
    SEL_MAIN  = 3'b100,
    SEL_ZERO  = 3'b101,
    SEL_BYP   = 3'b110,
    SEL_MAIN4 = 3'b111
  } tsel_e;
endpackage

// File: rtl/edge_rise.sv
module edge_rise (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;

  a_r10_one_cycle_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tog_div.sv
module tog_div #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic [CW-1:0] half_i,
  output logic          div_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      div_o <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      div_o <= 1'b0;
    end else if (tick_i) begin
      if (cnt_q >= half_i - CW'(1)) begin
        cnt_q <= '0;
        div_o <= ~div_o;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  // output only moves on a source edge
  a_r7_hold_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(div_o));
endmodule

// File: rtl/mod_m_cnt.sv
module mod_m_cnt #(
  parameter int MW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic [MW-1:0] m_i,
  output logic          pulse_o
);
  logic [MW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else if (clr_i) begin
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else if (tick_i) begin
      if (m_i <= MW'(1)) begin
        cnt_q   <= '0;
        pulse_o <= 1'b1;
      end else if (cnt_q >= m_i - MW'(1)) begin
        cnt_q   <= '0;
        pulse_o <= 1'b1;
      end else begin
        cnt_q   <= cnt_q + MW'(1);
        pulse_o <= 1'b0;
      end
    end
  end

  a_r5_rise_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_o) |-> $past(tick_i));
  a_r9_small_m_pulses: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !clr_i && m_i <= MW'(1)) |=> pulse_o);
endmodule

// File: rtl/test_sel_bypass.sv
module test_sel_bypass
  import test_sel_pkg::*;
#(
  parameter int MW       = 9,
  parameter int NW       = 2,
  parameter int REF_DIV  = 16,
  parameter int MAIN_DIV = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    tsel_i,
  input  logic [MW-1:0] m_val_i,
  input  logic [NW-1:0] n_code_i,
  input  logic          sclk_i,
  input  logic          sdo_i,
  input  logic          pll_clk_i,
  input  logic          ref_clk_i,
  output logic          test_o,
  output logic          fout_o
);
  localparam int NHW   = 1 << NW;
  localparam int RW    = $clog2(REF_DIV);
  localparam int MDW   = $clog2(MAIN_DIV);
  localparam int NSRC  = 3;
  localparam int S_SCK = 0;
  localparam int S_PLL = 1;
  localparam int S_REF = 2;

  logic [NSRC-1:0] src_lvl, src_rise;
  logic [2:0]      sel_q;
  logic            restart, bypass;
  logic            sdo_q, m_out, n_out, ref_out, main4_out;

  assign src_lvl = {ref_clk_i, pll_clk_i, sclk_i};

  for (genvar g = 0; g < NSRC; g++) begin : g_edge
    edge_rise u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (src_lvl[g]),
      .rise_o (src_rise[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= SEL_ZERO;
      sdo_q <= 1'b0;
    end else begin
      sel_q <= tsel_i;
      if (src_rise[S_SCK]) sdo_q <= sdo_i;
    end
  end

  assign restart = (tsel_i != sel_q);
  assign bypass  = (tsel_i == SEL_BYP);

  mod_m_cnt #(.MW(MW)) u_mcnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (restart),
    .tick_i  (bypass ? src_rise[S_SCK] : src_rise[S_PLL]),
    .m_i     (m_val_i),
    .pulse_o (m_out)
  );

  tog_div #(.CW(NHW)) u_ndiv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (restart),
    .tick_i (bypass & src_rise[S_SCK]),
    .half_i (NHW'(1) << n_code_i),
    .div_o  (n_out)
  );

  tog_div #(.CW(RW)) u_refdiv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (restart),
    .tick_i (src_rise[S_REF]),
    .half_i (RW'(REF_DIV / 2)),
    .div_o  (ref_out)
  );

  tog_div #(.CW(MDW)) u_maindiv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (restart),
    .tick_i (src_rise[S_PLL]),
    .half_i (MDW'(MAIN_DIV / 2)),
    .div_o  (main4_out)
  );

  always_comb begin
    unique case (tsel_i)
      SEL_SHIFT: test_o = sdo_q;
      SEL_ONE:   test_o = 1'b1;
      SEL_REF16: test_o = ref_out;
      SEL_MCNT:  test_o = m_out;
      SEL_MAIN:  test_o = pll_clk_i;
      SEL_ZERO:  test_o = 1'b0;
      SEL_BYP:   test_o = m_out;
      default:   test_o = main4_out;
    endcase
  end

  assign fout_o = bypass ? n_out : pll_clk_i;

  a_r2_sdo_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !src_rise[S_SCK] |=> $stable(sdo_q));
  a_r10_restart_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart && bypass) |=> (!bypass || !fout_o));
  a_r7_quiet_without_sclk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bypass && $stable(tsel_i) && !src_rise[S_SCK]) |=> (!bypass || $stable(fout_o)));
endmodule

// File: tb/tb_test_sel_bypass.sv
module tb_test_sel_bypass;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic [2:0] tsel;
  logic [8:0] m_val;
  logic [1:0] n_code;
  logic       sclk, sdo, pll_clk, ref_clk;
  logic       test_o, fout_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  test_sel_bypass dut (
    .clk_i(clk), .rst_ni(rst_ni), .tsel_i(tsel), .m_val_i(m_val),
    .n_code_i(n_code), .sclk_i(sclk), .sdo_i(sdo), .pll_clk_i(pll_clk),
    .ref_clk_i(ref_clk), .test_o(test_o), .fout_o(fout_o)
  );

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  // 0 = sclk, 1 = pll, 2 = ref
  task automatic pulse(input int which);
    case (which)
      0: sclk = 1'b1; 1: pll_clk = 1'b1; default: ref_clk = 1'b1;
    endcase
    step();
    case (which)
      0: sclk = 1'b0; 1: pll_clk = 1'b0; default: ref_clk = 1'b0;
    endcase
    step();
  endtask

  task automatic select(input logic [2:0] code);
    tsel = (code == 3'b001) ? 3'b101 : 3'b001;
    step();
    tsel = code;
    step();
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; tsel = 3'b110; m_val = 9'd5; n_code = 2'd0;
    sclk = 0; sdo = 0; pll_clk = 0; ref_clk = 0;
    step(); step();
    chk("R1 test_o in reset", test_o, 1'b0);
    chk("R1 fout_o in reset", fout_o, 1'b0);
    rst_ni = 1'b1;
    step();
  endtask

  task automatic t_shift();
    select(3'b000);
    sdo = 1'b1; pulse(0);
    chk("R2 captured 1", test_o, 1'b1);
    sdo = 1'b0; step(); step();
    chk("R2 no edge holds", test_o, 1'b1);
    pulse(0);
    chk("R2 captured 0", test_o, 1'b0);
  endtask

  task automatic t_const();
    select(3'b001);
    pll_clk = 1; ref_clk = 1; sclk = 1; step();
    chk("R3 code 001", test_o, 1'b1);
    pll_clk = 0; ref_clk = 0; sclk = 0; step();
    chk("R3 code 001 low inputs", test_o, 1'b1);
    select(3'b101);
    pll_clk = 1; step();
    chk("R3 code 101", test_o, 1'b0);
    pll_clk = 0; step();
  endtask

  task automatic t_ref16();
    select(3'b010);
    for (int k = 1; k <= 32; k++) begin
      pulse(2);
      chk("R4 ref div16", test_o, 1'((k >> 3) & 1));
    end
  endtask

  task automatic t_mcnt();
    m_val = 9'd5;
    select(3'b011);
    for (int k = 1; k <= 12; k++) begin
      pulse(1);
      chk("R5 M counter main clk", test_o, (k % 5) == 0);
      chk("R11 fout follows main", fout_o, 1'b0);
    end
  endtask

  task automatic t_main();
    select(3'b100);
    pll_clk = 1'b1; #1;
    chk("R6 passthrough high", test_o, 1'b1);
    chk("R11 fout high", fout_o, 1'b1);
    pll_clk = 1'b0; #1;
    chk("R6 passthrough low", test_o, 1'b0);
    step();
    select(3'b111);
    for (int k = 1; k <= 8; k++) begin
      pulse(1);
      chk("R6 main div4", test_o, 1'((k >> 1) & 1));
    end
  endtask

  task automatic t_bypass_n();
    m_val = 9'd3;
    for (int c = 0; c < 4; c++) begin
      n_code = 2'(c);
      select(3'b110);
      for (int k = 1; k <= 2 * (1 << c) + 1; k++) begin
        pulse(0);
        chk("R7 bypass N divider", fout_o, 1'((k / (1 << c)) & 1));
        chk("R8 bypass M counter", test_o, (k % 3) == 0);
      end
    end
  endtask

  task automatic t_small_m();
    n_code = 2'd0;
    for (int mv = 0; mv < 2; mv++) begin
      m_val = 9'(mv);
      select(3'b110);
      for (int k = 0; k < 3; k++) begin
        pulse(0);
        chk("R9 small M pulses", test_o, 1'b1);
      end
    end
  endtask

  task automatic t_restart();
    n_code = 2'd1; m_val = 9'd4;
    select(3'b110);
    pulse(0);
    chk("R10 partial count", fout_o, 1'b0);
    tsel = 3'b101; step();
    tsel = 3'b110; step();
    pulse(0);
    chk("R10 N restarted", fout_o, 1'b0);
    pulse(0);
    chk("R10 N full half", fout_o, 1'b1);
    pulse(0);
    chk("R10 M restarted no early pulse", test_o, 1'b0);
    pulse(0);
    chk("R10 M pulse after full count", test_o, 1'b1);
  endtask

  initial begin
    t_reset();
    t_shift();
    t_const();
    t_ref16();
    t_mcnt();
    t_main();
    t_bypass_n();
    t_small_m();
    t_restart();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule